// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a simple valid/ready request port to a byte-wide asynchronous static RAM array. The array is built from four banks. A host presents a single read or write with a 21-bit byte address. The controller turns that request into chip-select, write-enable and output-enable strobes with the timing that the memory needs. Read data comes back on a response port as a one-cycle pulse.

The two top address bits pick one of four active-low bank selects, and the full address is driven to the array. Each strobe interval is counted in clock cycles. These counts are worked out from two parameters, the clock period in nanoseconds and a speed grade (85, 100 or 120 ns). Each count is the nanosecond minimum rounded up to whole cycles.

The controller sequences the strobes so that chip select and write enable are both inactive whenever the address register changes. It counts separate intervals for the read access, the write pulse, the write recovery and the bus turnaround after a read. The bidirectional data bus appears as separate output data, output-drive and input data signals.

Top module: `sram_bus_ctrl`

## Requirements
- R1: Once reset has been released, every bank select, write enable and output enable is high, the data driver is off, `req_ready` is 1 and `rsp_valid` is 0.
- R2: While a chip select is active, exactly one bank select is low, namely bank number `addr[20:19]`. Whenever the controller is not accessing the memory, all bank selects are high.
- R3: A read drives the selected bank select and `mem_oe_n` low, with `mem_we_n` high, for exactly the read-access count of cycles. It starts in the cycle after the request is accepted.
- R4: Read data is sampled from `dq_in` on the clock edge that ends the read-access count. It is presented on `rsp_rdata` together with a one-cycle `rsp_valid` pulse in the following cycle.
- R5: A write drives the selected bank select and `mem_we_n` low, with `mem_oe_n` high, for exactly the write-pulse count of cycles. It starts in the cycle after the request is accepted.
- R6: `dq_drive` is 1 from the second cycle of the write pulse through its last cycle, and 0 at all other times. While it is 1, `dq_out` carries the accepted write data.
- R7: `mem_addr` holds the accepted address for the whole operation. It changes only at an edge that follows a cycle in which all bank selects and write enable were high.
- R8: After a write pulse, all strobes stay high for the recovery count of cycles before the controller is ready again. After a read, they stay high for the turnaround count of cycles.
- R9: `req_ready` is 1 only while the controller is idle. A request is accepted on an edge where both `req_valid` and `req_ready` are 1, and requests run one at a time in acceptance order.
- R10: Each interval count is the ceiling of its nanosecond minimum divided by the clock period. The write pulse is also at least one cycle longer than the data-setup minimum. The write-pulse count plus the recovery count covers the write cycle time. With a 10 ns clock and the 85 ns grade, the counts are read 9, write pulse 6, recovery 3 and turnaround 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address; bits 20:19 pick the bank |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 21 | Address to the memory array |
| mem_cs_n | output | 4 | Active-low bank selects |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| dq_out | output | 8 | Data driven towards the memory |
| dq_drive | output | 1 | Enables the data bus driver |
| dq_in | input | 8 | Data read from the memory bus |

## Verification
The bench builds the controller with a 10 ns clock and the 85 ns grade. That makes the counts 9, 6, 3 and 3, so every pulse width and gap can be measured cycle by cycle against fixed expected values. The behavioural memory in the bench returns a junk pattern until the ninth consecutive cycle of output enable. An early capture therefore returns wrong data. Requests cover every bank, both address extremes, read-after-write and write-after-read, and a request held while the controller is busy, so the turnaround and recovery gaps are all exercised.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_TURN,
        ST_WR,
        ST_REC
    } seq_state_e;

    // Strobe intents, active high; inverted at the pins
    typedef struct packed {
        logic cs;
        logic we;
        logic oe;
        logic drive;
    } strobe_t;

    function automatic int ceil_div(int n, int d);
        return (n + d - 1) / d;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int grade_cycle_ns(int g);
        if (g == 120) return 120;
        else if (g == 100) return 100;
        else return 85;
    endfunction

    function automatic int grade_pulse_ns(int g);
        if (g == 120) return 70;
        else if (g == 100) return 60;
        else return 55;
    endfunction

    function automatic int grade_setup_ns(int g);
        if (g == 120) return 45;
        else if (g == 100) return 40;
        else return 35;
    endfunction

    function automatic int grade_float_ns(int g);
        if (g == 120) return 45;
        else if (g == 100) return 35;
        else return 30;
    endfunction

    localparam int WR_RECOVER_NS = 3;

    function automatic int rd_cycles(int g, int p);
        return imax(1, ceil_div(grade_cycle_ns(g), p));
    endfunction

    // The driver starts one cycle late, so the setup needs one extra cycle
    function automatic int wp_cycles(int g, int p);
        return imax(ceil_div(grade_pulse_ns(g), p), ceil_div(grade_setup_ns(g), p) + 1);
    endfunction

    function automatic int rec_cycles(int g, int p);
        return imax(imax(1, ceil_div(WR_RECOVER_NS, p)),
                    ceil_div(grade_cycle_ns(g), p) - wp_cycles(g, p));
    endfunction

    function automatic int turn_cycles(int g, int p);
        return imax(1, ceil_div(grade_float_ns(g), p));
    endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC   = 9,
    parameter int WP_CYC   = 6,
    parameter int REC_CYC  = 3,
    parameter int TURN_CYC = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    req_write,
    output logic    req_ready,
    output logic    accept,
    output logic    capture,
    output strobe_t strb
);

    localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(REC_CYC, TURN_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim;
    logic             last;

    always_comb begin
        case (state_q)
            ST_RD:   lim = CNT_W'(RD_CYC - 1);
            ST_TURN: lim = CNT_W'(TURN_CYC - 1);
            ST_WR:   lim = CNT_W'(WP_CYC - 1);
            ST_REC:  lim = CNT_W'(REC_CYC - 1);
            default: lim = '0;
        endcase
    end

    assign last      = (cnt_q == lim);
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (state_q == ST_RD) && last;

    always_comb begin
        state_d = state_q;
        cnt_d   = last ? '0 : cnt_q + 1'b1;
        case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (accept) state_d = req_write ? ST_WR : ST_RD;
            end
            ST_RD:   if (last) state_d = ST_TURN;
            ST_TURN: if (last) state_d = ST_IDLE;
            ST_WR:   if (last) state_d = ST_REC;
            ST_REC:  if (last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        strb = '0;
        case (state_q)
            ST_RD: begin
                strb.cs = 1'b1;
                strb.oe = 1'b1;
            end
            ST_WR: begin
                strb.cs    = 1'b1;
                strb.we    = 1'b1;
                strb.drive = (cnt_q != '0);
            end
            default: strb = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/sram_bank_decode.sv
module sram_bank_decode #(
    parameter int ADDR_W    = 21,
    parameter int BANK_BITS = 2,
    localparam int NBANK    = 1 << BANK_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    output logic [NBANK-1:0]  cs_n
);

    logic [BANK_BITS-1:0] bank;
    assign bank = addr[ADDR_W-1 -: BANK_BITS];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign cs_n[g] = !(en && (bank == BANK_BITS'(g)));
    end

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rsp_rdata <= dq_in;
            rsp_valid <= capture;
        end
    end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 21,
    parameter int DATA_W        = 8,
    parameter int BANK_BITS     = 2,
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_GRADE   = 85,
    localparam int NBANK        = 1 << BANK_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NBANK-1:0]  mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive,
    input  logic [DATA_W-1:0] dq_in
);

    localparam int RD_CYC   = rd_cycles(SPEED_GRADE, CLK_PERIOD_NS);
    localparam int WP_CYC   = wp_cycles(SPEED_GRADE, CLK_PERIOD_NS);
    localparam int REC_CYC  = rec_cycles(SPEED_GRADE, CLK_PERIOD_NS);
    localparam int TURN_CYC = turn_cycles(SPEED_GRADE, CLK_PERIOD_NS);

    strobe_t strb;
    logic    accept;
    logic    capture;

    sram_seq_fsm #(
        .RD_CYC  (RD_CYC),
        .WP_CYC  (WP_CYC),
        .REC_CYC (REC_CYC),
        .TURN_CYC(TURN_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_ready(req_ready),
        .accept   (accept),
        .capture  (capture),
        .strb     (strb)
    );

    sram_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .capture  (capture),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .dq_in    (dq_in),
        .addr_q   (mem_addr),
        .wdata_q  (dq_out),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    sram_bank_decode #(
        .ADDR_W   (ADDR_W),
        .BANK_BITS(BANK_BITS)
    ) u_dec (
        .addr(mem_addr),
        .en  (strb.cs),
        .cs_n(mem_cs_n)
    );

    assign mem_we_n = !strb.we;
    assign mem_oe_n = !strb.oe;
    assign dq_drive = strb.drive;

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
    parameter int ADDR_W = 21,
    parameter int NBANK  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NBANK-1:0]  mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              dq_drive
);

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_cs_n)); // R2

    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n || !mem_oe_n) |-> !(&mem_cs_n)); // R2

    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!mem_we_n && !mem_oe_n)); // R5

    AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
        dq_drive |-> (!mem_we_n && mem_oe_n)); // R6

    AST_DRIVE_LATE: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> !dq_drive); // R6

    AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> $past(&mem_cs_n && mem_we_n)); // R7

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (&mem_cs_n && mem_we_n && mem_oe_n)); // R9

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R4

    AST_RSP_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(!mem_oe_n) && mem_oe_n)); // R4

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .NBANK (NBANK)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .dq_drive (dq_drive)
);

// File: tb/test_sram_bus_ctrl.sv
`timescale 1ns/1ps
module test_sram_bus_ctrl;

    // R10: expected counts for a 10 ns clock and the 85 ns grade
    localparam int EXP_RD   = 9;
    localparam int EXP_WP   = 6;
    localparam int EXP_REC  = 3;
    localparam int EXP_TURN = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [20:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_we_n;
    logic        mem_oe_n;
    logic [7:0]  dq_out;
    logic        dq_drive;
    logic [7:0]  dq_in = 8'hA5;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sram_bus_ctrl #(
        .CLK_PERIOD_NS(10),
        .SPEED_GRADE  (85)
    ) i_sram_bus_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_ready(req_ready),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .mem_addr (mem_addr),
        .mem_cs_n (mem_cs_n),
        .mem_we_n (mem_we_n),
        .mem_oe_n (mem_oe_n),
        .dq_out   (dq_out),
        .dq_drive (dq_drive),
        .dq_in    (dq_in)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // ---------------- behavioural memory ----------------
    logic [7:0] sram [int];
    int         oe_run = 0;

    always @(negedge clk) begin
        if (!(&mem_cs_n) && !mem_oe_n && mem_we_n) oe_run++;
        else oe_run = 0;
        if (oe_run >= EXP_RD)
            dq_in <= sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 8'h00;
        else
            dq_in <= 8'hA5;
    end

    always @(posedge clk) begin
        if (!mem_we_n && !(&mem_cs_n) && dq_drive) sram[int'(mem_addr)] = dq_out;
    end

    // ---------------- reference timeline ----------------
    typedef struct {
        bit          cs;
        bit          we;
        bit          oe;
        bit          drv;
        bit          rsp;
        logic [20:0] addr;
        logic [7:0]  data;
    } slot_t;

    slot_t      plan_q[$];
    slot_t      cur;
    bit         busy = 0;
    logic [7:0] ref_mem [int];
    logic [7:0] rd_exp[$];

    task automatic schedule(bit w, logic [20:0] a, logic [7:0] d);
        slot_t s;
        s.addr = a;
        s.data = d;
        if (w) begin
            ref_mem[int'(a)] = d;
            for (int i = 0; i < EXP_WP; i++) begin
                s.cs = 1; s.we = 1; s.oe = 0; s.rsp = 0; s.drv = (i != 0);
                plan_q.push_back(s);
            end
            for (int i = 0; i < EXP_REC; i++) begin
                s.cs = 0; s.we = 0; s.oe = 0; s.drv = 0; s.rsp = 0;
                plan_q.push_back(s);
            end
        end else begin
            rd_exp.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
            for (int i = 0; i < EXP_RD; i++) begin
                s.cs = 1; s.we = 0; s.oe = 1; s.drv = 0; s.rsp = 0;
                plan_q.push_back(s);
            end
            for (int i = 0; i < EXP_TURN; i++) begin
                s.cs = 0; s.we = 0; s.oe = 0; s.drv = 0; s.rsp = (i == 0);
                plan_q.push_back(s);
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            plan_q.delete();
            busy = 0;
        end else begin
            if (!busy && req_valid) schedule(req_write, req_addr, req_wdata);
            if (plan_q.size() > 0) begin
                cur  = plan_q.pop_front();
                busy = 1;
            end else begin
                busy = 0;
            end
        end
    end

    always @(negedge clk) begin
        logic [3:0] exp_cs;
        if (!rst && !done) begin
            exp_cs = (busy && cur.cs) ? ~(4'b0001 << cur.addr[20:19]) : 4'b1111;
            chk(mem_cs_n == exp_cs, "R2/R3 bank select", 32'(mem_cs_n), 32'(exp_cs));
            chk(mem_we_n == !(busy && cur.we), "R5/R10 write enable", 32'(mem_we_n), 32'(!(busy && cur.we)));
            chk(mem_oe_n == !(busy && cur.oe), "R3/R10 output enable", 32'(mem_oe_n), 32'(!(busy && cur.oe)));
            chk(dq_drive == (busy && cur.drv), "R6 data driver", 32'(dq_drive), 32'(busy && cur.drv));
            if (busy && cur.drv)
                chk(dq_out == cur.data, "R6 write data", 32'(dq_out), 32'(cur.data));
            chk(req_ready == !busy, "R8/R9 ready", 32'(req_ready), 32'(!busy));
            chk(rsp_valid == (busy && cur.rsp), "R4 response pulse", 32'(rsp_valid), 32'(busy && cur.rsp));
            if (rsp_valid && rd_exp.size() > 0)
                chk(rsp_rdata == rd_exp.pop_front(), "R4 read data", 32'(rsp_rdata), 32'(ref_mem_last()));
            if (busy)
                chk(mem_addr == cur.addr, "R7 address hold", 32'(mem_addr), 32'(cur.addr));
        end
    end

    // Only used to print the expected value after it has been popped
    logic [7:0] last_exp;
    function automatic logic [7:0] ref_mem_last();
        return last_exp;
    endfunction
    always @(posedge clk) if (rd_exp.size() > 0) last_exp = rd_exp[0];

    // ---------------- stimulus ----------------
    task automatic send(bit w, logic [20:0] a, logic [7:0] d);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy || !req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        chk(mem_cs_n == 4'hF, "R1 bank selects", 32'(mem_cs_n), 32'hF);
        chk(mem_we_n && mem_oe_n, "R1 enables", 32'({mem_we_n, mem_oe_n}), 32'h3);
        chk(!dq_drive, "R1 driver", 32'(dq_drive), 32'h0);
        chk(req_ready, "R1 ready", 32'(req_ready), 32'h1);
        chk(!rsp_valid, "R1 response", 32'(rsp_valid), 32'h0);

        // R2: one write into every bank, then read back
        for (int b = 0; b < 4; b++) send(1'b1, {b[1:0], 19'h0ABC + 19'(b)}, 8'h10 + 8'(b));
        for (int b = 3; b >= 0; b--) send(1'b0, {b[1:0], 19'h0ABC + 19'(b)}, 8'h00);
        // address extremes
        send(1'b1, 21'h1FFFFF, 8'h3C);
        send(1'b1, 21'h000000, 8'hC3);
        send(1'b0, 21'h000000, 8'h00);
        send(1'b0, 21'h1FFFFF, 8'h00);
        // unwritten location reads as zero in the memory model
        send(1'b0, 21'h0F0F0F, 8'h00);
        // read after write to the same location, write after read (turnaround, R8)
        send(1'b1, 21'h123456, 8'h77);
        send(1'b0, 21'h123456, 8'h00);
        send(1'b1, 21'h123456, 8'h88);
        send(1'b0, 21'h123456, 8'h00);
        // R9: request held while busy is taken only once idle
        req_valid = 1'b1; req_write = 1'b0; req_addr = 21'h1FFFFF; req_wdata = 8'h00;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        repeat (5) @(negedge clk);
        chk(rd_exp.size() == 0, "R4 all responses returned", 32'(rd_exp.size()), 32'h0);
        done = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        done = 1;
        report();
    end

endmodule